// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a four-wire serial slave that lets an external controller read and write a small bank of 8-bit control registers, such as per-channel gain settings. The select, clock and data-in pins are oversampled in a fast system clock domain. Every frame is 16 serial clocks long and is bracketed by an active-low select. The first byte carries a direction flag and a register address. The second byte carries write data. During the same frame, the slave returns the contents of the addressed register on the data-out pin.

A write takes effect only when the select returns high after the complete 16 clocks. Incomplete frames leave both the registers and the latched address untouched. Clock pulses beyond the sixteenth are discarded. The register contents drive plain control outputs. There is no streaming data path, so no valid/ready handshake and no back-pressure apply. The serial clock must stay slow enough that each level lasts longer than the synchronizer depth plus two system cycles.

Top module: `spi_reg_slave`

## Requirements
- R1: A falling edge of spi_csn starts a new frame and clears the bit counter, so a frame that follows an aborted one is decoded from its own first bit.
- R2: Frame bits are sampled on rising spi_sclk, MSB first. Frame bit 15 is the direction flag (1 = read, 0 = write), bits 14:8 are the register address, and bits 7:0 are the data byte.
- R3: Registers change only when spi_csn rises after exactly 16 counted clocks. A write-flag frame then stores the data byte into the addressed register. A read-flag frame stores nothing.
- R4: If spi_csn rises after fewer than 16 clocks, neither any register nor cur_addr changes.
- R5: Rising spi_sclk edges after the sixteenth in one frame are not shifted in, so the committed frame is the first 16 bits.
- R6: At the falling spi_sclk edge that ends the eighth clock, spi_miso presents bit 7 of the register named by the first byte. Bits 6 down to 0 follow on falls nine to fifteen, so the controller captures them on rising edges nine to sixteen. This happens for both read and write frames, and a write returns the value held before the write.
- R7: spi_miso_oe is high only while the select is asserted. From the start of a frame until readback begins, spi_miso is 0.
- R8: Writes to addresses at or above NUM_REGS are dropped, and reading such an address returns 00h.
- R9: After reset, every register and cur_addr read 00h.
- R10: On every complete-frame commit, cur_addr takes the 7-bit address from the first byte, whatever the direction flag is and whether or not the address is implemented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_csn | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data into the slave |
| spi_miso | output | 1 | Serial data out of the slave |
| spi_miso_oe | output | 1 | Output enable for the external tri-state data-out driver |
| cur_addr | output | 7 | Address latched by the last complete frame |
| regs_flat | output | 8*NUM_REGS | All register contents; register i sits at bits 8*i+7:8*i |

## Verification
Full write frames and full read frames are sent to several addresses with distinct data. This tells correct address decoding apart from an off-by-one shift, and a read-only frame apart from one that also writes. A write that overwrites a known value checks that readback returns the value held before the write. Frames cut short at 5 and 10 clocks and a frame stretched to 20 clocks with ones on the extra bits show whether the commit depends on the exact count and whether late clocks are shifted in. Frames to an unimplemented address show that writes to it are dropped, that reads from it return zero, and that the address is still latched.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 7;
  localparam int FRAME_BITS = 2 * BYTE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic  rd;
    addr_t addr;
    byte_t data;
  } frame_t;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int           STAGES  = 2,
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_active,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             mosi,
  input  byte_t            rd_byte,
  output addr_t            peek_addr,
  output logic             miso,
  output logic             commit,
  output frame_t           commit_frame,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] HALFWAY = CNT_W'(BYTE_W);

  logic [FRAME_BITS-1:0] in_sh;
  byte_t                 out_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      in_sh   <= '0;
      out_sh  <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      in_sh   <= '0;
      out_sh  <= '0;
    end else if (cs_active) begin
      if (sclk_rise && bit_cnt != FULL) begin
        in_sh   <= {in_sh[FRAME_BITS-2:0], mosi};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (sclk_fall) begin
        if (bit_cnt == HALFWAY)
          out_sh <= rd_byte;
        else if (bit_cnt > HALFWAY && bit_cnt < FULL)
          out_sh <= {out_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign peek_addr    = addr_t'(in_sh[ADDR_W-1:0]);
  assign miso         = out_sh[BYTE_W-1];
  assign commit       = cs_rise && (bit_cnt == FULL);
  assign commit_frame = frame_t'(in_sh);
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regs_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  addr_t                      wr_addr,
  input  byte_t                      wr_data,
  input  addr_t                      rd_addr,
  output byte_t                      rd_data,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  byte_t regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))
        regs[g] <= wr_data;
    end
    assign regs_flat[g*BYTE_W +: BYTE_W] = regs[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_addr == ADDR_W'(i)) rd_data = regs[i];
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_regs_pkg::*;
#(
  parameter int NUM_REGS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_sclk,
  input  logic                       spi_csn,
  input  logic                       spi_mosi,
  output logic                       spi_miso,
  output logic                       spi_miso_oe,
  output logic [ADDR_W-1:0]          cur_addr,
  output logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  logic sclk_s, csn_s, mosi_s;
  logic sclk_d, csn_d;
  logic sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic commit;
  logic [CNT_W-1:0] bit_cnt;
  frame_t commit_frame;
  addr_t  peek_addr;
  byte_t  rd_byte;

  spi_pin_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_csn, spi_mosi}),
    .q({sclk_s, csn_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      csn_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      csn_d  <= csn_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;
  assign cs_fall   = ~csn_s & csn_d;
  assign cs_rise   = csn_s & ~csn_d;

  spi_frame_engine u_frame (
    .clk(clk), .rst_n(rst_n),
    .cs_active(~csn_s), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi(mosi_s),
    .rd_byte(rd_byte), .peek_addr(peek_addr), .miso(spi_miso),
    .commit(commit), .commit_frame(commit_frame), .bit_cnt(bit_cnt)
  );

  spi_reg_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(commit && !commit_frame.rd),
    .wr_addr(commit_frame.addr), .wr_data(commit_frame.data),
    .rd_addr(peek_addr), .rd_data(rd_byte),
    .regs_flat(regs_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_addr <= '0;
    else if (commit)
      cur_addr <= commit_frame.addr;
  end

  assign spi_miso_oe = ~csn_s;
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_regs_pkg::*;
#(
  parameter int NUM_REGS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_fall,
  input logic                       cs_rise,
  input logic [CNT_W-1:0]           bit_cnt,
  input logic                       miso,
  input logic [ADDR_W-1:0]          cur_addr,
  input logic [NUM_REGS*BYTE_W-1:0] regs_flat
);
  AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> (bit_cnt == '0)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS)); // R5
  AST_REG_ONLY_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(regs_flat)); // R3
  AST_SHORT_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && bit_cnt != CNT_W'(FRAME_BITS)) |=> ($stable(regs_flat) && $stable(cur_addr))); // R4
  AST_ADDR_ONLY_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(cur_addr)); // R10
  AST_MISO_QUIET_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !miso); // R7
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_fall(cs_fall), .cs_rise(cs_rise),
  .bit_cnt(bit_cnt), .miso(spi_miso), .cur_addr(cur_addr), .regs_flat(regs_flat)
);

// File: tb/sim_spi_reg_slave.sv
module sim_spi_reg_slave;
  localparam int NREG = 4;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;
  logic [6:0] cur_addr;
  logic [NREG*8-1:0] regs_flat;

  int n_checks = 0;
  int n_fail = 0;
  logic [7:0] model [NREG];
  logic oe_seen;

  always #4 clk = ~clk;

  spi_reg_slave #(.NUM_REGS(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .cur_addr(cur_addr), .regs_flat(regs_flat)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req);
    for (int i = 0; i < NREG; i++)
      chk(req, 32'(regs_flat[i*8 +: 8]), 32'(model[i]));
  endtask

  task automatic xfer(input logic [15:0] w, input int nclk, input logic extra,
                      output logic [7:0] rd);
    rd = '0;
    oe_seen = 1'b0;
    spi_csn = 1'b0;
    tick(HALF);
    for (int i = 0; i < nclk; i++) begin
      spi_mosi = (i < 16) ? w[15-i] : extra;
      tick(HALF);
      if (i >= 8 && i < 16) rd[15-i] = spi_miso;
      if (i == 4) oe_seen = spi_miso_oe;
      spi_sclk = 1'b1;
      tick(HALF);
      spi_sclk = 1'b0;
    end
    tick(HALF);
    spi_csn = 1'b1;
    tick(2 * HALF);
  endtask

  task automatic t_reset;
    chk("R9 regs after reset", 32'(regs_flat), 32'h0);
    chk("R9 cur_addr after reset", 32'(cur_addr), 32'h0);
    chk("R7 oe idle", 32'(spi_miso_oe), 32'h0);
  endtask

  task automatic t_write_read;
    logic [7:0] rd;
    xfer({1'b0, 7'd1, 8'hA5}, 16, 1'b0, rd);
    model[1] = 8'hA5;
    chk_regs("R3 write reg1");
    chk("R10 addr after write", 32'(cur_addr), 32'd1);
    chk("R7 oe during frame", 32'(oe_seen), 32'd1);
    chk("R6 write frame returns old", 32'(rd), 32'h00);
    xfer({1'b1, 7'd1, 8'hFF}, 16, 1'b0, rd);
    chk("R6 read reg1", 32'(rd), 32'hA5);
    chk_regs("R3 read does not write");
    xfer({1'b0, 7'd1, 8'h5A}, 16, 1'b0, rd);
    model[1] = 8'h5A;
    chk("R6 overwrite returns previous", 32'(rd), 32'hA5);
    chk_regs("R3 overwrite reg1");
  endtask

  task automatic t_addressing;
    logic [7:0] rd;
    xfer({1'b0, 7'd3, 8'hC3}, 16, 1'b0, rd);
    model[3] = 8'hC3;
    xfer({1'b0, 7'd0, 8'h81}, 16, 1'b0, rd);
    model[0] = 8'h81;
    chk_regs("R2 two addresses");
    xfer({1'b1, 7'd0, 8'h00}, 16, 1'b0, rd);
    chk("R2 read reg0", 32'(rd), 32'h81);
    xfer({1'b1, 7'd3, 8'h00}, 16, 1'b0, rd);
    chk("R2 read reg3", 32'(rd), 32'hC3);
    chk("R10 addr after read", 32'(cur_addr), 32'd3);
  endtask

  task automatic t_short_and_restart;
    logic [7:0] rd;
    xfer({1'b0, 7'd2, 8'h7E}, 10, 1'b0, rd);
    chk_regs("R4 short frame no write");
    chk("R4 short frame keeps addr", 32'(cur_addr), 32'd3);
    xfer({1'b0, 7'd2, 8'h11}, 5, 1'b0, rd);
    xfer({1'b0, 7'd2, 8'h66}, 16, 1'b0, rd);
    model[2] = 8'h66;
    chk_regs("R1 frame after abort");
    chk("R1 addr after abort", 32'(cur_addr), 32'd2);
  endtask

  task automatic t_long;
    logic [7:0] rd;
    xfer({1'b0, 7'd0, 8'h0F}, 20, 1'b1, rd);
    model[0] = 8'h0F;
    chk_regs("R5 extra clocks ignored");
    chk("R5 addr with extra clocks", 32'(cur_addr), 32'd0);
  endtask

  task automatic t_unimpl;
    logic [7:0] rd;
    xfer({1'b0, 7'h50, 8'hFF}, 16, 1'b0, rd);
    chk_regs("R8 write to unimplemented dropped");
    chk("R10 unimplemented addr latched", 32'(cur_addr), 32'h50);
    xfer({1'b1, 7'h50, 8'h00}, 16, 1'b0, rd);
    chk("R8 read unimplemented", 32'(rd), 32'h00);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=done");
    report();
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_write_read();
    t_addressing();
    t_short_and_restart();
    t_long();
    t_unimpl();
    report();
  end
endmodule